// File: doc/BRIEF.md
# Serial Command Frame Slave Engine

This block is the command engine of a slave device on a single-wire serial link. A byte-level receiver hands it one byte at a time, and a byte-level transmitter takes the reply bytes it produces. The engine assembles the incoming bytes into frames. Each frame holds a sync byte, then a command byte that carries a 3-bit device address and a 5-bit command number. A command-dependent number of argument bytes follows, and most frames end with a master-computed checksum. The engine checks each frame and then acts on it.

Configuration writes update a small register file that drives the rest of the device. Measurement commands open a record interval of fixed length, modelled as a timer. A readback request makes the engine return the whole register file followed by a checksum that the engine computes itself. Any newly accepted command preempts whatever is in progress: it ends a running record interval, and if it is not itself a readback it cancels a reply that has not finished. The first reply byte is held back by exactly one bit period after the request.

Top module: `uart_cmd_slave`

## Requirements
- R1: A frame starts only with the byte 0x55. Any other byte seen while the parser is idle is discarded, and the parser stays idle.
- R2: The command byte holds the device address in bits 7:5 and the command number in bits 4:0. A frame whose address differs from DEV_ADDR is parsed to its end and then ignored.
- R3: Command 10 carries an index byte and then a value byte. If the index is below NREG, that register takes the value in the cycle that accepts the checksum byte. Any other index changes nothing. Register i appears on cfg_regs bits 8i+7:8i.
- R4: The checksum is the bitwise inverse of the 8-bit end-around-carry sum of the command byte and all argument bytes. A frame whose checksum does not match changes no state.
- R5: Commands 0 to 5 and 18 to 23 carry no argument bytes, only a checksum. After acceptance, busy is high for exactly REC_CYCLES cycles, and rec_cmd shows the command number.
- R6: Any command accepted while busy is high ends the interval in the cycle of acceptance. A new record command restarts the full interval.
- R7: Command 9 is a readback request made of the sync byte and the command byte only. The reply is registers 0 to NREG-1 in order, then the inverse of their end-around-carry sum.
- R8: tx_valid rises exactly BIT_CYCLES cycles after the clock edge that accepts the readback command byte. While tx_ready is low, tx_valid and tx_byte hold.
- R9: A non-readback command accepted during a reply cancels the rest of that reply.
- R10: A gap of fewer than 15 bit periods between the bytes of a frame is tolerated. After 15 bit periods with no byte, a partial frame is dropped.
- R11: Command numbers not named above carry no argument bytes and have no effect beyond the preemption in R6 and R9.
- R12: After reset, cfg_regs is zero, busy is low, rec_cmd is zero and tx_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | One-cycle strobe: a received byte is present |
| rx_byte | input | 8 | Received byte |
| tx_ready | input | 1 | Transmitter accepts tx_byte |
| tx_valid | output | 1 | A reply byte is offered |
| tx_byte | output | 8 | Reply byte |
| busy | output | 1 | Record interval active |
| rec_cmd | output | 5 | Command number of the latest record interval |
| cfg_regs | output | NREG*8 | Register file contents |

## Verification
Writes are driven with well-formed frames, with a corrupted checksum, with an index beyond the file, with a foreign address and behind a non-sync lead byte. Together these separate acceptance from each way a frame can be rejected. Record frames are sent alone, followed by a write, by a second record and by a readback, which tells natural expiry apart from preemption and from restart. Readbacks run with the transmitter always ready, with a stalling ready pattern and with ready held low and then cancelled, which isolates the exact reply delay, the hold rule and cancellation. Frames with long but legal gaps are compared against a frame broken by a gap past the limit.

// File: rtl/uart_cmd_pkg.sv
package uart_cmd_pkg;

  localparam logic [7:0] SYNC_BYTE     = 8'h55;
  localparam logic [4:0] CMD_READBACK  = 5'd9;
  localparam logic [4:0] CMD_REG_WRITE = 5'd10;

  typedef enum logic [1:0] {PS_IDLE, PS_CMD, PS_DATA, PS_CSUM} pstate_t;
  typedef enum logic [1:0] {RS_IDLE, RS_WAIT, RS_SEND} rstate_t;

  // 8-bit add with the carry folded back into bit 0
  function automatic logic [7:0] eac_add(input logic [7:0] a, input logic [7:0] b);
    logic [8:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[7:0] + {7'd0, s[8]};
  endfunction

  function automatic logic is_record(input logic [4:0] c);
    return (c <= 5'd5) || ((c >= 5'd18) && (c <= 5'd23));
  endfunction

  function automatic logic [1:0] arg_count(input logic [4:0] c);
    return (c == CMD_REG_WRITE) ? 2'd2 : 2'd0;
  endfunction

endpackage

// File: rtl/uart_frm_parser.sv
module uart_frm_parser
  import uart_cmd_pkg::*;
#(
  parameter logic [2:0] DEV_ADDR       = 3'd2,
  parameter int         TIMEOUT_CYCLES = 120
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  output logic       acc_valid,
  output logic [4:0] acc_cmd,
  output logic [7:0] acc_arg0,
  output logic [7:0] acc_arg1
);

  localparam int              GW       = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [GW-1:0]   GAP_LAST = GW'(TIMEOUT_CYCLES - 1);

  pstate_t       state_q, state_d;
  logic [7:0]    cmd_q, cmd_d;
  logic [7:0]    sum_q, sum_d;
  logic [7:0]    arg0_q, arg0_d;
  logic [7:0]    arg1_q, arg1_d;
  logic [1:0]    cnt_q, cnt_d;
  logic [GW-1:0] gap_q, gap_d;
  logic          upd;

  assign upd = rx_valid || (state_q != PS_IDLE);

  always_comb begin
    state_d   = state_q;
    cmd_d     = cmd_q;
    sum_d     = sum_q;
    arg0_d    = arg0_q;
    arg1_d    = arg1_q;
    cnt_d     = cnt_q;
    gap_d     = gap_q;
    acc_valid = 1'b0;
    if (rx_valid) begin
      gap_d = '0;
      unique case (state_q)
        PS_IDLE: if (rx_byte == SYNC_BYTE) state_d = PS_CMD;
        PS_CMD: begin
          cmd_d = rx_byte;
          sum_d = rx_byte;
          cnt_d = 2'd0;
          if (rx_byte[4:0] == CMD_READBACK) begin
            acc_valid = (rx_byte[7:5] == DEV_ADDR);
            state_d   = PS_IDLE;
          end else if (arg_count(rx_byte[4:0]) != 2'd0) begin
            state_d = PS_DATA;
          end else begin
            state_d = PS_CSUM;
          end
        end
        PS_DATA: begin
          if (cnt_q == 2'd0) arg0_d = rx_byte;
          else               arg1_d = rx_byte;
          sum_d = eac_add(sum_q, rx_byte);
          cnt_d = cnt_q + 2'd1;
          if (cnt_d == arg_count(cmd_q[4:0])) state_d = PS_CSUM;
        end
        PS_CSUM: begin
          acc_valid = (rx_byte == ~sum_q) && (cmd_q[7:5] == DEV_ADDR);
          state_d   = PS_IDLE;
        end
        default: state_d = PS_IDLE;
      endcase
    end else if (state_q != PS_IDLE) begin
      if (gap_q == GAP_LAST) begin
        state_d = PS_IDLE;
        gap_d   = '0;
      end else begin
        gap_d = gap_q + 1'b1;
      end
    end
  end

  assign acc_cmd  = (state_q == PS_CMD) ? rx_byte[4:0] : cmd_q[4:0];
  assign acc_arg0 = arg0_q;
  assign acc_arg1 = arg1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PS_IDLE;
      cmd_q   <= '0;
      sum_q   <= '0;
      arg0_q  <= '0;
      arg1_q  <= '0;
      cnt_q   <= '0;
      gap_q   <= '0;
    end else if (upd) begin
      state_q <= state_d;
      cmd_q   <= cmd_d;
      sum_q   <= sum_d;
      arg0_q  <= arg0_d;
      arg1_q  <= arg1_d;
      cnt_q   <= cnt_d;
      gap_q   <= gap_d;
    end
  end

  // R1: a non-sync byte while idle never opens a frame
  a_r1_sync_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_IDLE && rx_valid && rx_byte != SYNC_BYTE) |=> (state_q == PS_IDLE));

  // R10: a stalled partial frame is dropped when the gap limit is reached
  a_r10_gap_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != PS_IDLE && !rx_valid && gap_q == GAP_LAST) |=> (state_q == PS_IDLE));

  // R2: nothing is accepted before a command byte has been seen
  a_r2_no_accept_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_IDLE) |-> !acc_valid);

endmodule

// File: rtl/uart_cfg_regs.sv
module uart_cfg_regs #(
  parameter int NREG = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        wr_addr,
  input  logic [7:0]        wr_data,
  output logic [NREG*8-1:0] regs_flat
);

  localparam logic [8:0] NREG_W = 9'(NREG);

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic       hit;
    logic [7:0] val_q;
    assign hit = wr_en && (wr_addr == 8'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   val_q <= '0;
      else if (hit) val_q <= wr_data;
    end
    assign regs_flat[8*i +: 8] = val_q;
  end

  // R3: an index beyond the file leaves every register as it was
  a_r3_oob_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ({1'b0, wr_addr} >= NREG_W)) |=> $stable(regs_flat));

  // R4: without a write strobe the file holds
  a_r4_no_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(regs_flat));

endmodule

// File: rtl/uart_rec_timer.sv
module uart_rec_timer #(
  parameter int REC_CYCLES = 200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       abort,
  input  logic [4:0] cmd_in,
  output logic       busy,
  output logic [4:0] rec_cmd
);

  localparam int            CW       = $clog2(REC_CYCLES + 1);
  localparam logic [CW-1:0] CNT_LOAD = CW'(REC_CYCLES - 1);

  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [4:0]    cmd_q;
  logic          upd;

  assign upd = start || abort || busy_q;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (start) begin
      busy_d = 1'b1;
      cnt_d  = CNT_LOAD;
    end else if (abort) begin
      busy_d = 1'b0;
      cnt_d  = '0;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (upd) begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cmd_q <= '0;
    else if (start) cmd_q <= cmd_in;
  end

  assign busy    = busy_q;
  assign rec_cmd = cmd_q;

  // R5: a record start opens the interval and tags it with the command
  a_r5_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && rec_cmd == $past(cmd_in)));

  // R6: preemption without a new record ends the interval at once
  a_r6_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && !start) |=> !busy);

endmodule

// File: rtl/uart_reply_tx.sv
module uart_reply_tx
  import uart_cmd_pkg::*;
#(
  parameter int NREG       = 4,
  parameter int BIT_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cancel,
  input  logic [NREG*8-1:0] regs_flat,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic [7:0]        tx_byte
);

  localparam int            IW       = $clog2(NREG + 1);
  localparam int            WW       = $clog2(BIT_CYCLES + 1);
  localparam logic [IW-1:0] IDX_LAST = IW'(NREG);
  localparam logic [WW-1:0] WAIT_LD  = WW'(BIT_CYCLES - 1);

  rstate_t       state_q, state_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [WW-1:0] wcnt_q, wcnt_d;
  logic [7:0]    csum, cur;
  logic          upd;

  always_comb begin
    logic [7:0] acc;
    acc = 8'd0;
    for (int i = 0; i < NREG; i++) acc = eac_add(acc, regs_flat[8*i +: 8]);
    csum = ~acc;
  end

  always_comb begin
    cur = csum;
    for (int i = 0; i < NREG; i++) begin
      if (idx_q == IW'(i)) cur = regs_flat[8*i +: 8];
    end
  end

  assign upd = start || cancel || (state_q != RS_IDLE);

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    wcnt_d  = wcnt_q;
    if (start) begin
      state_d = RS_WAIT;
      idx_d   = '0;
      wcnt_d  = WAIT_LD;
    end else if (cancel) begin
      state_d = RS_IDLE;
    end else begin
      unique case (state_q)
        RS_WAIT: begin
          if (wcnt_q == '0) state_d = RS_SEND;
          else              wcnt_d  = wcnt_q - 1'b1;
        end
        RS_SEND: begin
          if (tx_ready) begin
            if (idx_q == IDX_LAST) state_d = RS_IDLE;
            else                   idx_d   = idx_q + 1'b1;
          end
        end
        default: state_d = RS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RS_IDLE;
      idx_q   <= '0;
      wcnt_q  <= '0;
    end else if (upd) begin
      state_q <= state_d;
      idx_q   <= idx_d;
      wcnt_q  <= wcnt_d;
    end
  end

  assign tx_valid = (state_q == RS_SEND);
  assign tx_byte  = cur;

  // R8: an offered byte waits, unchanged, for the transmitter
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !start && !cancel) |=> (tx_valid && $stable(tx_byte)));

  // R8: no byte is offered in the cycle after a request
  a_r8_no_early: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !tx_valid);

  // R9: cancellation silences the reply
  a_r9_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    (cancel && !start) |=> !tx_valid);

endmodule

// File: rtl/uart_cmd_slave.sv
module uart_cmd_slave
  import uart_cmd_pkg::*;
#(
  parameter logic [2:0] DEV_ADDR     = 3'd2,
  parameter int         NREG         = 4,
  parameter int         BIT_CYCLES   = 8,
  parameter int         TIMEOUT_BITS = 15,
  parameter int         REC_CYCLES   = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic [7:0]        tx_byte,
  output logic              busy,
  output logic [4:0]        rec_cmd,
  output logic [NREG*8-1:0] cfg_regs
);

  localparam int TIMEOUT_CYCLES = TIMEOUT_BITS * BIT_CYCLES;

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic       acc_valid;
  logic [4:0] acc_cmd;
  logic [7:0] acc_arg0, acc_arg1;
  logic       wr_en, rec_start, reply_start, reply_cancel;

  uart_frm_parser #(
    .DEV_ADDR       (DEV_ADDR),
    .TIMEOUT_CYCLES (TIMEOUT_CYCLES)
  ) u_parser (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .rx_valid  (rx_valid),
    .rx_byte   (rx_byte),
    .acc_valid (acc_valid),
    .acc_cmd   (acc_cmd),
    .acc_arg0  (acc_arg0),
    .acc_arg1  (acc_arg1)
  );

  assign wr_en        = acc_valid && (acc_cmd == CMD_REG_WRITE);
  assign rec_start    = acc_valid && is_record(acc_cmd);
  assign reply_start  = acc_valid && (acc_cmd == CMD_READBACK);
  assign reply_cancel = acc_valid && !reply_start;

  uart_cfg_regs #(
    .NREG (NREG)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wr_en     (wr_en),
    .wr_addr   (acc_arg0),
    .wr_data   (acc_arg1),
    .regs_flat (cfg_regs)
  );

  uart_rec_timer #(
    .REC_CYCLES (REC_CYCLES)
  ) u_rec (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .start   (rec_start),
    .abort   (acc_valid),
    .cmd_in  (acc_cmd),
    .busy    (busy),
    .rec_cmd (rec_cmd)
  );

  uart_reply_tx #(
    .NREG       (NREG),
    .BIT_CYCLES (BIT_CYCLES)
  ) u_reply (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start     (reply_start),
    .cancel    (reply_cancel),
    .regs_flat (cfg_regs),
    .tx_ready  (tx_ready),
    .tx_valid  (tx_valid),
    .tx_byte   (tx_byte)
  );

  // R11: an accepted command triggers at most one kind of action
  a_r11_one_action: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0({wr_en, rec_start, reply_start}));

  // R12: outputs are quiet while held in reset
  a_r12_reset_quiet: assert property (@(posedge clk)
    !rst_int_n |-> (!busy && !tx_valid));

endmodule

// File: tb/tb_uart_cmd_slave.sv
`timescale 1ns/1ps
module tb_uart_cmd_slave;

  localparam int         BIT  = 8;
  localparam int         NREG = 4;
  localparam int         REC  = 200;
  localparam int         TO   = 15 * BIT;
  localparam logic [2:0] DEV  = 3'd2;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              rx_valid;
  logic [7:0]        rx_byte;
  logic              tx_ready;
  logic              tx_valid;
  logic [7:0]        tx_byte;
  logic              busy;
  logic [4:0]        rec_cmd;
  logic [NREG*8-1:0] cfg_regs;

  always #2.5 clk = ~clk;

  uart_cmd_slave #(
    .DEV_ADDR     (DEV),
    .NREG         (NREG),
    .BIT_CYCLES   (BIT),
    .TIMEOUT_BITS (15),
    .REC_CYCLES   (REC)
  ) dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_valid (rx_valid),
    .rx_byte  (rx_byte),
    .tx_ready (tx_ready),
    .tx_valid (tx_valid),
    .tx_byte  (tx_byte),
    .busy     (busy),
    .rec_cmd  (rec_cmd),
    .cfg_regs (cfg_regs)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;
  int bp    = 0;
  int cyc   = 0;
  int got[$];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int cks(input int q[$]);
    int s = 0;
    foreach (q[i]) s += q[i];
    while (s > 255) s = (s & 255) + (s >> 8);
    return 255 - s;
  endfunction

  function automatic bit is_rec(input int c);
    return (c <= 5) || (c >= 18 && c <= 23);
  endfunction

  // ---------------- behavioural reference model ----------------
  int m_ps, m_gap, m_need, m_cmd, m_adr, m_b;
  int m_fq[$];
  int m_regs[NREG];
  int m_busy_left, m_rec, m_wcnt;
  int m_rq[$];
  bit m_send, m_act;

  function automatic void accept();
    int rb[$];
    m_busy_left = 0;
    if (is_rec(m_cmd)) begin
      m_busy_left = REC;
      m_rec       = m_cmd;
    end
    if (m_cmd == 10 && m_fq[1] < NREG) m_regs[m_fq[1]] = m_fq[2];
    m_rq.delete();
    if (m_cmd == 9) begin
      foreach (m_regs[i]) begin
        m_rq.push_back(m_regs[i]);
        rb.push_back(m_regs[i]);
      end
      m_rq.push_back(cks(rb));
      m_wcnt = BIT;
      m_send = 0;
      m_act  = 1;
    end else begin
      m_act  = 0;
      m_send = 0;
    end
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ps = 0; m_gap = 0; m_need = 0; m_cmd = 0; m_adr = 0;
      m_fq.delete(); m_rq.delete();
      foreach (m_regs[i]) m_regs[i] = 0;
      m_busy_left = 0; m_rec = 0; m_wcnt = 0; m_send = 0; m_act = 0;
    end else begin
      if (m_act) begin
        if (m_send) begin
          if (tx_ready) begin
            void'(m_rq.pop_front());
            if (m_rq.size() == 0) begin m_act = 0; m_send = 0; end
          end
        end else begin
          m_wcnt--;
          if (m_wcnt == 0) m_send = 1;
        end
      end
      if (m_busy_left > 0) m_busy_left--;
      if (rx_valid) begin
        m_b   = int'(rx_byte);
        m_gap = 0;
        case (m_ps)
          0: if (m_b == 85) m_ps = 1;
          1: begin
            m_fq.delete();
            m_fq.push_back(m_b);
            m_cmd = m_b & 31;
            m_adr = m_b >> 5;
            if (m_cmd == 9) begin
              if (m_adr == int'(DEV)) accept();
              m_ps = 0;
            end else begin
              m_need = (m_cmd == 10) ? 2 : 0;
              m_ps   = (m_need > 0) ? 2 : 3;
            end
          end
          2: begin
            m_fq.push_back(m_b);
            if (m_fq.size() == m_need + 1) m_ps = 3;
          end
          default: begin
            if (m_b == cks(m_fq) && m_adr == int'(DEV)) accept();
            m_ps = 0;
          end
        endcase
      end else if (m_ps != 0) begin
        m_gap++;
        if (m_gap >= TO) begin m_ps = 0; m_gap = 0; end
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int i = 0; i < NREG; i++)
        chk(int'(cfg_regs[8*i +: 8]) == m_regs[i], "R3 cfg_regs model", cfg_regs[8*i +: 8], m_regs[i]);
      chk(busy == (m_busy_left > 0), "R5 busy model", busy, m_busy_left > 0);
      chk(int'(rec_cmd) == m_rec, "R5 rec_cmd model", rec_cmd, m_rec);
      chk(tx_valid == (m_act && m_send), "R8 tx_valid model", tx_valid, m_act && m_send);
      if (tx_valid && m_act && m_send)
        chk(int'(tx_byte) == m_rq[0], "R7 tx_byte model", tx_byte, m_rq[0]);
    end
  end

  // transmitter side: ready pattern and byte capture
  always @(negedge clk) begin
    cyc++;
    case (bp)
      0:       tx_ready = 1'b1;
      1:       tx_ready = (cyc % 3 != 0);
      default: tx_ready = 1'b0;
    endcase
    if (rst_n && tx_valid && tx_ready) got.push_back(int'(tx_byte));
  end

  // ---------------- stimulus helpers ----------------
  task automatic send_byte(input int b, input int gap);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_byte  = 8'(b);
    @(negedge clk);
    rx_valid = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic send_raw(input int q[$], input int gap, input int gap_last);
    foreach (q[i]) send_byte(q[i], (i == q.size() - 1) ? gap_last : gap);
  endtask

  task automatic send_cmd(input int cmdb, input int args[$], input int gap, input int gap_last);
    int body[$];
    int q[$];
    body.push_back(cmdb);
    foreach (args[i]) body.push_back(args[i]);
    q.push_back(85);
    foreach (body[i]) q.push_back(body[i]);
    q.push_back(cks(body));
    send_raw(q, gap, gap_last);
  endtask

  task automatic wr(input int idx, input int val);
    send_cmd(8'h4A, '{idx, val}, 80, 80);
  endtask

  function automatic int reg_at(input int i);
    return int'(cfg_regs[8*i +: 8]);
  endfunction

  task automatic readback_check(input string tag, input int exp[$]);
    int n;
    got.delete();
    send_byte(85, 10);
    send_byte(8'h49, 0);
    chk(tx_valid == 1'b0, {tag, " R8 quiet after request"}, tx_valid, 0);
    n = 0;
    while (!tx_valid && n < 1000) begin
      @(negedge clk);
      n++;
    end
    chk(n == BIT, {tag, " R8 reply delay"}, n, BIT);
    n = 0;
    while (got.size() < NREG + 1 && n < 1000) begin
      @(negedge clk);
      n++;
    end
    repeat (3) @(negedge clk);
    chk(got.size() == NREG + 1, {tag, " R7 reply length"}, got.size(), NREG + 1);
    foreach (exp[i])
      if (i < got.size()) chk(got[i] == exp[i], {tag, " R7 reply byte"}, got[i], exp[i]);
  endtask

  // ---------------- directed sequence ----------------
  initial begin
    int exp[$];
    rst_n = 1'b0; rx_valid = 1'b0; rx_byte = 8'h00; tx_ready = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R12 reset state
    chk(cfg_regs == '0, "R12 cfg_regs after reset", cfg_regs, 0);
    chk(busy == 1'b0, "R12 busy after reset", busy, 0);
    chk(rec_cmd == 5'd0, "R12 rec_cmd after reset", rec_cmd, 0);
    chk(tx_valid == 1'b0, "R12 tx_valid after reset", tx_valid, 0);

    // R3 register writes
    wr(1, 8'h3C);
    wr(2, 8'hA5);
    chk(reg_at(1) == 8'h3C, "R3 write reg1", reg_at(1), 8'h3C);
    chk(reg_at(2) == 8'hA5, "R3 write reg2", reg_at(2), 8'hA5);

    // R4 corrupted checksum
    send_raw('{85, 8'h4A, 1, 8'h99, cks('{8'h4A, 1, 8'h99}) ^ 1}, 80, 80);
    chk(reg_at(1) == 8'h3C, "R4 bad checksum drops write", reg_at(1), 8'h3C);

    // R3 index beyond file
    wr(7, 8'h11);
    chk(cfg_regs == 32'h00A53C00, "R3 out-of-range index ignored", cfg_regs, 32'h00A53C00);

    // R1 non-sync lead byte, then recovery
    send_raw('{8'h54, 8'h4A, 3, 8'h66, cks('{8'h4A, 3, 8'h66})}, 80, 80);
    chk(reg_at(3) == 0, "R1 frame without sync ignored", reg_at(3), 0);
    wr(3, 8'h66);
    chk(reg_at(3) == 8'h66, "R1 proper sync accepted", reg_at(3), 8'h66);

    // R2 foreign device address
    send_cmd(8'hAA, '{0, 8'h5A}, 80, 80);
    chk(reg_at(0) == 0, "R2 foreign address write ignored", reg_at(0), 0);
    send_cmd(8'hA3, '{}, 10, 10);
    chk(busy == 1'b0, "R2 foreign address record ignored", busy, 0);

    // R5 record interval length
    send_cmd(8'h43, '{}, 10, 0);
    chk(busy == 1'b1, "R5 busy after record", busy, 1);
    chk(rec_cmd == 5'd3, "R5 rec_cmd", rec_cmd, 3);
    repeat (REC - 2) @(negedge clk);
    chk(busy == 1'b1, "R5 busy at last interval cycle", busy, 1);
    repeat (2) @(negedge clk);
    chk(busy == 1'b0, "R5 busy ends after interval", busy, 0);

    // R6 write preempts record
    send_cmd(8'h54, '{}, 10, 40);
    chk(busy == 1'b1 && rec_cmd == 5'd20, "R6 record 20 running", {busy, rec_cmd}, {1'b1, 5'd20});
    send_cmd(8'h4A, '{0, 8'h5A}, 10, 0);
    chk(busy == 1'b0, "R6 write ends record", busy, 0);
    chk(reg_at(0) == 8'h5A, "R6 preempting write applied", reg_at(0), 8'h5A);

    // R6 record restarts record (command 21 byte equals the sync value)
    send_cmd(8'h42, '{}, 10, 40);
    send_cmd(8'h55, '{}, 10, 0);
    chk(rec_cmd == 5'd21, "R6 rec_cmd after restart", rec_cmd, 21);
    repeat (REC - 2) @(negedge clk);
    chk(busy == 1'b1, "R6 restarted interval still running", busy, 1);
    repeat (2) @(negedge clk);
    chk(busy == 1'b0, "R6 restarted interval ends", busy, 0);

    // R6 readback ends record
    send_cmd(8'h45, '{}, 10, 20);
    send_byte(85, 10);
    send_byte(8'h49, 0);
    chk(busy == 1'b0, "R6 readback ends record", busy, 0);
    repeat (40) @(negedge clk);

    // R7 / R8 reply with transmitter always ready
    exp = '{8'h5A, 8'h3C, 8'hA5, 8'h66};
    exp.push_back(cks('{8'h5A, 8'h3C, 8'hA5, 8'h66}));
    bp = 0;
    readback_check("ready", exp);

    // R8 reply under stalls
    bp = 1;
    readback_check("stall", exp);
    bp = 0;
    repeat (10) @(negedge clk);

    // R9 / R11 cancellation by an unlisted command
    bp = 2;
    got.delete();
    send_byte(85, 10);
    send_byte(8'h49, 30);
    chk(tx_valid == 1'b1, "R9 reply pending", tx_valid, 1);
    send_cmd(8'h4E, '{}, 10, 0);
    chk(tx_valid == 1'b0, "R9 reply cancelled", tx_valid, 0);
    bp = 0;
    repeat (20) @(negedge clk);
    chk(got.size() == 0, "R9 no bytes after cancel", got.size(), 0);
    chk(cfg_regs == 32'h66A53C5A, "R11 unlisted command leaves registers", cfg_regs, 32'h66A53C5A);
    chk(busy == 1'b0, "R11 unlisted command starts no record", busy, 0);

    // R10 long legal gaps
    send_cmd(8'h4A, '{2, 8'h71}, 110, 20);
    chk(reg_at(2) == 8'h71, "R10 frame with long gaps accepted", reg_at(2), 8'h71);
    // R10 gap past the limit
    send_byte(85, 20);
    send_byte(8'h4A, 200);
    send_raw('{2, 8'h77, cks('{8'h4A, 2, 8'h77})}, 20, 20);
    chk(reg_at(2) == 8'h71, "R10 timed-out frame dropped", reg_at(2), 8'h71);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule